// File: doc/BRIEF.md
# Unaligned Byte/Word Memory Access Splitter

This unit sits between a processor core and a 16-bit memory built from two 8-bit banks. The memory is byte addressable: the even byte of each 16-bit word travels on the low lane, bits 7:0, and the odd byte travels on the high lane, bits 15:8. The core issues byte or word reads and writes at any byte address, and stored data is little-endian.

Each request becomes one or two memory cycles. A byte access or a word access at an even address takes a single cycle. A word access at an odd address takes two byte cycles, and the unit swaps the byte lanes on the way in and on the way out. The core therefore sees every word access as one seamless operation. A one-cycle done pulse tells the core that the access has finished and that read data is valid.

The memory holds each cycle open until it returns a one-cycle ready. The unit keeps its memory outputs steady until that ready arrives.

Top module: `split_access_unit`

## Requirements
- R1: From reset, and at any time no access is in progress, both bank enables and `cpu_done` are low.
- R2: A word access (`cpu_word`=1) at an even byte address uses one memory cycle. In that cycle both enables are high and `mem_addr` = address>>1. The low result byte comes from the low lane and the high result byte from the high lane. A write drives `cpu_wdata` unchanged.
- R3: A byte access (`cpu_word`=0) uses one cycle with only one enable high: the low enable for an even address, the high enable for an odd address. A read returns the byte zero-extended in `cpu_rdata[7:0]`. A write stores `cpu_wdata[7:0]` in the selected byte only.
- R4: A word read at an odd address takes two cycles. The first uses only the high enable at word address>>1. The second uses only the low enable at (address>>1)+1. The result is {second byte, first byte}.
- R5: A word write at an odd address takes two cycles. The first drives `cpu_wdata[7:0]` on the high lane with only the high enable. The second drives `cpu_wdata[15:8]` on the low lane with only the low enable at the next word address. The neighbouring bytes stay unchanged.
- R6: An odd word access at the top byte address wraps its second cycle to word address 0.
- R7: `cpu_done` is high for exactly one cycle per accepted request. That cycle immediately follows the cycle in which the final memory cycle saw `mem_rdy`.
- R8: `cpu_req` is accepted only while the unit is idle. A request raised during an access has no effect.
- R9: While an enable is high and `mem_rdy` is low, the address, enables, write flag and write data hold steady.
- R10: `mem_we` is high during the memory cycles of a write (`cpu_wr`=1) and low during those of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Core request, sampled while idle |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_word | input | 1 | 1 = word access, 0 = byte access |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| cpu_rdata | output | 16 | Read result, valid from the done pulse until the next request |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W-1 | Word address to the banks |
| mem_en_lo | output | 1 | Even (low lane) bank enable |
| mem_en_hi | output | 1 | Odd (high lane) bank enable |
| mem_we | output | 1 | Write strobe qualifier |
| mem_wdata | output | 16 | Write data on both lanes |
| mem_rdata | input | 16 | Read data from both lanes |
| mem_rdy | input | 1 | One-cycle completion of a memory cycle |

## Verification
The assertions check four things on every cycle. The done pulse is one cycle wide and follows a ready. The memory outputs hold steady while a cycle waits. The enables stay low whenever the unit is idle. Both lanes are enabled together only for an even word access. Only the bench scenarios can show the rest: the lane swap and byte order of odd word reads and writes, the wrap to word zero, that neighbouring bytes survive a split write, and that a request raised mid-access leaves memory untouched.

// File: rtl/sau_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the sequencer state type for the
// access splitter. Assumes a data path of two byte lanes.
package sau_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = BYTE_W * LANES;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_DONE   = 2'd3
    } sau_state_e;
endpackage

// File: rtl/sau_seq.sv
`timescale 1ns/1ps
// Module: sau_seq
// Access sequencer. It accepts a request only in idle, runs one or two
// memory cycles (two when the request is split) and spends one cycle
// in the done state. Assumes mem_rdy is seen only while a cycle is open.
module sau_seq
    import sau_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req,
    input  logic       mem_rdy,
    input  logic       split,
    output sau_state_e state,
    output logic       accept,
    output logic       done
);
    sau_state_e state_q, state_d;

    // Next-state selection for the access sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cpu_req) state_d = ST_FIRST;
            ST_FIRST:  if (mem_rdy) state_d = split ? ST_SECOND : ST_DONE;
            ST_SECOND: if (mem_rdy) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state  = state_q;
    assign accept = (state_q == ST_IDLE) && cpu_req;
    assign done   = (state_q == ST_DONE);
endmodule

// File: rtl/sau_plan.sv
`timescale 1ns/1ps
// Module: sau_plan
// Combinational planner. From the latched request and the phase it
// forms the word address, the lane enables, the write-lane data and the
// result-byte load controls. Assumes phase two exists only for an
// odd-address word access.
module sau_plan
    import sau_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int WA_W  = ADDR_W - 1,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  sau_state_e          state,
    input  logic [ADDR_W-1:0]   addr_q,
    input  logic                word_q,
    input  logic                wr_q,
    input  logic [DATA_W-1:0]   wdata_q,
    input  logic                mem_rdy,
    output logic                split,
    output logic [WA_W-1:0]     mem_addr,
    output logic                mem_en_lo,
    output logic                mem_en_hi,
    output logic                mem_we,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic [LANES-1:0]    load,
    output logic [LANES*SEL_W-1:0] src
);
    logic            odd, act, ph2;
    logic [WA_W-1:0] wa;
    logic [BYTE_W-1:0] bsel;

    // Request decode: split flag, phase and word address.
    always_comb begin
        odd   = addr_q[0];
        split = word_q && odd;
        ph2   = (state == ST_SECOND);
        act   = (state == ST_FIRST) || ph2;
        wa    = addr_q[ADDR_W-1:1];
    end

    // Bus-side outputs: address (wrapping), enables and write lanes.
    always_comb begin
        mem_addr  = ph2 ? wa + {{(WA_W-1){1'b0}}, 1'b1} : wa;
        mem_en_lo = act && (ph2 || !odd);
        mem_en_hi = act && !ph2 && (odd || word_q);
        mem_we    = act && wr_q;
        bsel      = ph2 ? wdata_q[2*BYTE_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
        mem_wdata = (word_q && !odd) ? wdata_q : {LANES{bsel}};
    end

    // Result-byte loading: which result byte takes which lane, and when.
    always_comb begin
        load    = '0;
        src     = '0;
        load[0] = mem_rdy && (state == ST_FIRST);
        src[0*SEL_W +: SEL_W] = odd ? SEL_W'(1) : SEL_W'(0);
        load[1] = mem_rdy && word_q &&
                  (((state == ST_FIRST) && !odd) || ph2);
        src[1*SEL_W +: SEL_W] = ph2 ? SEL_W'(0) : SEL_W'(1);
    end
endmodule

// File: rtl/sau_lanes.sv
`timescale 1ns/1ps
// Module: sau_lanes
// Result assembly. One byte register per result byte loads from the
// lane picked by the planner; all clear when a request is accepted, so
// a byte read leaves the upper bytes zero.
module sau_lanes
    import sau_pkg::*;
#(
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic [LANES-1:0]       load,
    input  logic [LANES*SEL_W-1:0] src,
    input  logic [DATA_W-1:0]      rdata,
    output logic [DATA_W-1:0]      result
);
    for (genvar i = 0; i < LANES; i++) begin : g_byte
        logic [BYTE_W-1:0] b_q;
        logic [SEL_W-1:0]  s;
        assign s = src[i*SEL_W +: SEL_W];

        // Byte register i: clear on accept, load from selected lane.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) b_q <= '0;
            else if (load[i])    b_q <= rdata[s*BYTE_W +: BYTE_W];
        end

        assign result[i*BYTE_W +: BYTE_W] = b_q;
    end
endmodule

// File: rtl/split_access_unit.sv
`timescale 1ns/1ps
// Module: split_access_unit (top)
// Turns byte/word requests at any byte address into one or two cycles
// on a two-bank 16-bit memory, swapping lanes for odd word accesses.
// Assumes a one-cycle ready per memory cycle and a core that waits for
// done before issuing the next request.
module split_access_unit
    import sau_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int WA_W  = ADDR_W - 1,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_word,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic [WA_W-1:0]   mem_addr,
    output logic              mem_en_lo,
    output logic              mem_en_hi,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rdy
);
    sau_state_e            state;
    logic                  accept, split, busy;
    logic [ADDR_W-1:0]     addr_q;
    logic                  word_q, wr_q;
    logic [DATA_W-1:0]     wdata_q;
    logic [LANES-1:0]      load;
    logic [LANES*SEL_W-1:0] src;

    // Request capture: hold the accepted request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            word_q  <= 1'b0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= cpu_addr;
            word_q  <= cpu_word;
            wr_q    <= cpu_wr;
            wdata_q <= cpu_wdata;
        end
    end

    assign busy = (state != ST_IDLE);

    sau_seq seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_req (cpu_req),
        .mem_rdy (mem_rdy),
        .split   (split),
        .state   (state),
        .accept  (accept),
        .done    (cpu_done)
    );

    sau_plan #(.ADDR_W(ADDR_W)) plan_i (
        .state     (state),
        .addr_q    (addr_q),
        .word_q    (word_q),
        .wr_q      (wr_q),
        .wdata_q   (wdata_q),
        .mem_rdy   (mem_rdy),
        .split     (split),
        .mem_addr  (mem_addr),
        .mem_en_lo (mem_en_lo),
        .mem_en_hi (mem_en_hi),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .load      (load),
        .src       (src)
    );

    sau_lanes lanes_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .load   (load),
        .src    (src),
        .rdata  (mem_rdata),
        .result (cpu_rdata)
    );
endmodule

// File: rtl/sau_chk.sv
`timescale 1ns/1ps
// Module: sau_chk
// Property checker bound into split_access_unit. It watches the done
// pulse, the memory-side hold rule and the lane-enable rules.
module sau_chk
    import sau_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int WA_W  = ADDR_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              word_q,
    input logic              addr_lsb,
    input logic              cpu_done,
    input logic              mem_en_lo,
    input logic              mem_en_hi,
    input logic              mem_rdy,
    input logic [WA_W-1:0]   mem_addr,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata
);
    logic en_any;
    assign en_any = mem_en_lo || mem_en_hi;

    // R7: done lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R7: done follows a ready
    a_r7_done_after_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> $past(mem_rdy));

    // R9: outputs hold while a cycle waits
    a_r9_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (en_any && !mem_rdy) |=> ($stable(mem_addr) && $stable(mem_en_lo) &&
                                  $stable(mem_en_hi) && $stable(mem_we) &&
                                  $stable(mem_wdata)));

    // R1: no enables while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !en_any);

    // R2/R3: both lanes only for even word
    a_r2_both_lanes_even_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en_lo && mem_en_hi) |-> (word_q && !addr_lsb));
endmodule

bind split_access_unit sau_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .word_q    (word_q),
    .addr_lsb  (addr_q[0]),
    .cpu_done  (cpu_done),
    .mem_en_lo (mem_en_lo),
    .mem_en_hi (mem_en_hi),
    .mem_rdy   (mem_rdy),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
);

// File: tb/split_access_unit_tb_top.sv
`timescale 1ns/1ps
// Directed bench: a two-bank byte memory model with one wait cycle per
// access, a negedge bus monitor and one task per scenario.
module split_access_unit_tb_top;
    localparam int AW = 8;
    localparam int NW = 2 ** (AW - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_word = 1'b0, cpu_wr = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0, cpu_rdata, mem_wdata, mem_rdata;
    logic cpu_done, mem_en_lo, mem_en_hi, mem_we;
    logic mem_rdy = 1'b0;
    logic [AW-2:0] mem_addr;

    logic [7:0] bank_lo [0:NW-1];
    logic [7:0] bank_hi [0:NW-1];

    int total = 0, fails = 0;
    int tick = 0, last_rdy_tick = -10, done_n = 0;
    int lat_err = 0, wid_err = 0, hold_err = 0;
    logic prev_done = 1'b0, waiting = 1'b0;
    logic [AW-2:0] wait_addr = '0;
    int lg_n = 0;
    logic [AW-2:0] lg_addr [0:3];
    logic lg_lo [0:3], lg_hi [0:3], lg_we [0:3];
    logic [15:0] lg_wd [0:3];
    bit finished = 1'b0;

    always #10 clk = ~clk;

    split_access_unit #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_word(cpu_word), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .mem_addr(mem_addr),
        .mem_en_lo(mem_en_lo), .mem_en_hi(mem_en_hi), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy));

    function automatic logic [7:0] pat(input int b);
        return 8'((b * 7 + 3) & 255);
    endfunction

    assign mem_rdata = {bank_hi[mem_addr], bank_lo[mem_addr]};

    // Memory model: one wait cycle, ready for one cycle, lane writes.
    always @(posedge clk) begin
        if (!rst_n) mem_rdy <= 1'b0;
        else begin
            mem_rdy <= (mem_en_lo || mem_en_hi) && !mem_rdy;
            if (mem_rdy && mem_we && mem_en_lo) bank_lo[mem_addr] <= mem_wdata[7:0];
            if (mem_rdy && mem_we && mem_en_hi) bank_hi[mem_addr] <= mem_wdata[15:8];
        end
    end

    // Monitor away from the active edge.
    always @(negedge clk) begin
        tick++;
        if (rst_n) begin
            if (mem_en_lo || mem_en_hi) begin
                if (mem_rdy) begin
                    if (waiting && wait_addr != mem_addr) hold_err++;
                    waiting = 1'b0;
                    if (lg_n < 4) begin
                        lg_addr[lg_n] = mem_addr; lg_lo[lg_n] = mem_en_lo;
                        lg_hi[lg_n] = mem_en_hi; lg_we[lg_n] = mem_we;
                        lg_wd[lg_n] = mem_wdata;
                    end
                    lg_n++;
                    last_rdy_tick = tick;
                end else begin
                    waiting = 1'b1; wait_addr = mem_addr;
                end
            end
            if (cpu_done) begin
                done_n++;
                if (tick != last_rdy_tick + 1) lat_err++;
                if (prev_done) wid_err++;
            end
            prev_done = cpu_done;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Generic access: drive one request, wait for done, return data.
    task automatic access(input int a, input bit word, input bit wr,
                          input logic [15:0] wd, output logic [15:0] rd,
                          input bit intrude);
        int d0, n;
        @(posedge clk); #2;
        lg_n = 0; d0 = done_n;
        cpu_req = 1'b1; cpu_addr = AW'(a); cpu_word = word; cpu_wr = wr; cpu_wdata = wd;
        @(posedge clk); #2;
        cpu_req = 1'b0;
        if (intrude) begin
            // R8: request while busy, must be ignored
            cpu_req = 1'b1; cpu_addr = 8'h70; cpu_word = 1'b0; cpu_wr = 1'b1;
            cpu_wdata = 16'h0099;
            @(posedge clk); #2;
            cpu_req = 1'b0; cpu_wr = 1'b0;
        end
        n = 0;
        while (done_n == d0 && n < 40) begin @(posedge clk); #2; n++; end
        rd = cpu_rdata;
        repeat (3) @(posedge clk);
        #2;
        chk("R7 one done per request", done_n - d0, 1);
    endtask

    task automatic t_reset();
        chk("R1 reset done", int'(cpu_done), 0);
        chk("R1 reset enables", int'({mem_en_lo, mem_en_hi}), 0);
    endtask

    task automatic t_even_word_read();
        logic [15:0] rd;
        access(16'h10, 1, 0, 16'h0, rd, 0);
        chk("R2 even word data", rd, {pat(8'h11), pat(8'h10)});
        chk("R2 cycles", lg_n, 1);
        chk("R2 enables", {lg_lo[0], lg_hi[0]}, 2'b11);
        chk("R2 addr", lg_addr[0], 8'h08);
        chk("R10 read we low", lg_we[0], 0);
        chk("R1 idle after", int'({mem_en_lo, mem_en_hi}), 0);
    endtask

    task automatic t_odd_word_read();
        logic [15:0] rd;
        access(16'h21, 1, 0, 16'h0, rd, 0);
        chk("R4 odd word data", rd, {pat(8'h22), pat(8'h21)});
        chk("R4 cycles", lg_n, 2);
        chk("R4 first lane hi", {lg_lo[0], lg_hi[0]}, 2'b01);
        chk("R4 first addr", lg_addr[0], 8'h10);
        chk("R4 second lane lo", {lg_lo[1], lg_hi[1]}, 2'b10);
        chk("R4 second addr", lg_addr[1], 8'h11);
    endtask

    task automatic t_byte_reads();
        logic [15:0] rd;
        access(16'h30, 0, 0, 16'h0, rd, 0);
        chk("R3 even byte data", rd, {8'h00, pat(8'h30)});
        chk("R3 even byte lane", {lg_lo[0], lg_hi[0]}, 2'b10);
        access(16'h33, 0, 0, 16'h0, rd, 0);
        chk("R3 odd byte data", rd, {8'h00, pat(8'h33)});
        chk("R3 odd byte lane", {lg_lo[0], lg_hi[0]}, 2'b01);
        chk("R3 odd byte cycles", lg_n, 1);
    endtask

    task automatic t_even_word_write();
        logic [15:0] rd;
        access(16'h40, 1, 1, 16'hBEEF, rd, 0);
        chk("R2 write cycles", lg_n, 1);
        chk("R10 write we high", lg_we[0], 1);
        access(16'h40, 0, 0, 16'h0, rd, 0);
        chk("R2 write low byte", rd, 16'h00EF);
        access(16'h41, 0, 0, 16'h0, rd, 0);
        chk("R2 write high byte", rd, 16'h00BE);
    endtask

    task automatic t_odd_word_write();
        logic [15:0] rd;
        access(16'h51, 1, 1, 16'h1234, rd, 0);
        chk("R5 cycles", lg_n, 2);
        chk("R5 first lane", {lg_lo[0], lg_hi[0]}, 2'b01);
        chk("R5 first hi data", lg_wd[0][15:8], 8'h34);
        chk("R5 second lane", {lg_lo[1], lg_hi[1]}, 2'b10);
        chk("R5 second lo data", lg_wd[1][7:0], 8'h12);
        chk("R5 second addr", lg_addr[1], 8'h29);
        access(16'h50, 1, 0, 16'h0, rd, 0);
        chk("R5 word 50", rd, {8'h34, pat(8'h50)});
        access(16'h52, 1, 0, 16'h0, rd, 0);
        chk("R5 word 52", rd, {pat(8'h53), 8'h12});
    endtask

    task automatic t_byte_write();
        logic [15:0] rd;
        access(16'h61, 0, 1, 16'h77AB, rd, 0);
        chk("R3 byte write lane", {lg_lo[0], lg_hi[0]}, 2'b01);
        access(16'h60, 1, 0, 16'h0, rd, 0);
        chk("R3 byte write result", rd, {8'hAB, pat(8'h60)});
    endtask

    task automatic t_wrap();
        logic [15:0] rd;
        access(16'hFF, 1, 0, 16'h0, rd, 0);
        chk("R6 wrap read data", rd, {pat(0), pat(8'hFF)});
        chk("R6 wrap second addr", lg_addr[1], 0);
        chk("R6 wrap first addr", lg_addr[0], 8'h7F);
        access(16'hFF, 1, 1, 16'hCAFE, rd, 0);
        access(16'h00, 0, 0, 16'h0, rd, 0);
        chk("R6 wrap write byte 0", rd, 16'h00CA);
        access(16'hFF, 0, 0, 16'h0, rd, 0);
        chk("R6 wrap write byte FF", rd, 16'h00FE);
    endtask

    task automatic t_busy_ignored();
        logic [15:0] rd;
        access(16'h21, 1, 0, 16'h0, rd, 1);
        chk("R8 busy data", rd, {pat(8'h22), pat(8'h21)});
        chk("R8 busy cycles", lg_n, 2);
        access(16'h70, 0, 0, 16'h0, rd, 0);
        chk("R8 byte 70 untouched", rd, {8'h00, pat(8'h70)});
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            bank_lo[i] = pat(2 * i);
            bank_hi[i] = pat(2 * i + 1);
        end
        repeat (4) @(posedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #2;
        t_reset();
        t_even_word_read();
        t_odd_word_read();
        t_byte_reads();
        t_even_word_write();
        t_odd_word_write();
        t_byte_write();
        t_wrap();
        t_busy_ignored();
        chk("R7 done latency", lat_err, 0);
        chk("R7 done width", wid_err, 0);
        chk("R9 hold while waiting", hold_err, 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule